// File: doc/BRIEF.md
# Two-Slot TDM Serial Audio Slave Port

This block links a host register interface to an external audio converter. The converter is the timing master: it drives the bit clock and a one-bit frame marker, and the port follows both. Each frame is 32 bit clocks long and carries two 16-bit slot words. Outgoing words come from a two-entry transmit buffer and leave most significant bit first. Incoming words are gathered into a two-entry receive buffer. The host exchanges 24-bit words with the port, and the 16 audio bits fill the upper end of each word.

All converter-side inputs pass through a synchronizer chain clocked by the system clock, and the bit-clock edges are detected in that clock domain. The bit-clock edge that ends a bit period is the sampling edge. On it the port takes in receive data, watches for the frame marker, counts bits and slots, and moves to the next buffer entry. The opposite edge changes the transmit line. A buffer index that steps once per slot decides which entry each slot uses. The index returns to the first entry at the end of every frame and whenever a new frame marker arrives. Two sticky error flags report a transmit slot with no fresh host word and a receive word that lands on an unread one.

Top module: `tdm_slave_port`

## Requirements
- R1: After reset, sdout_o, both error flags, rx_valid_o, fsync_seen_o and rx_rdata_o are all zero.
- R2: A high level on fsync_i at a falling bit-clock edge starts a frame, and the next bit period is data bit 0. Each detected start gives a single one-cycle pulse on fsync_seen_o.
- R3: sdout_o changes only after rising bit-clock edges. Over data bits 0 to 31 of a frame it carries the slot-0 word and then the slot-1 word, each most significant bit first. The slot word is bits 23:8 of the host word written with tx_wr_i.
- R4: sdin_i is sampled at falling bit-clock edges, most significant bit first. Data bits 0 to 15 form slot 0 and data bits 16 to 31 form slot 1. A read returns the slot word in bits 23:8 of rx_rdata_o, and bits 7:0 are zero.
- R5: When a slot-k receive word is stored, rx_valid_o[k] pulses high for one system clock. At most one bit of rx_valid_o is high at a time.
- R6: The buffer index steps by one (modulo 2) per slot and returns to entry 0 at the last slot of a frame. A frame marker arriving mid-frame also returns it to entry 0, so the next frame uses entry 0 first for both transmit and receive.
- R7: urun_o is set when a slot's transmit word is loaded and the host has not written that slot since the word was last loaded. The port then sends the previous word again.
- R8: orun_o is set when a receive word completes while the previous word in the same entry is still unread. The new word replaces the old one.
- R9: Both error flags stay set until their clear input is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R10: A frame marker during data bit 31 is accepted, so frames can follow each other with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Bit clock from the converter |
| fsync_i | input | 1 | One-bit active-high frame marker |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| tx_wr_i | input | 1 | Write strobe for a transmit entry |
| tx_sel_i | input | 1 | Transmit entry selector |
| tx_wdata_i | input | 24 | Host transmit word; bits 23:8 are used |
| rx_rd_i | input | 1 | Read strobe that marks a receive entry consumed |
| rx_sel_i | input | 1 | Receive entry selector |
| rx_rdata_o | output | 24 | Selected receive entry, left aligned |
| urun_clr_i | input | 1 | Clears the underrun flag |
| orun_clr_i | input | 1 | Clears the overrun flag |
| rx_valid_o | output | 2 | Per-slot word-stored strobes |
| fsync_seen_o | output | 1 | Frame-start pulse |
| urun_o | output | 1 | Sticky transmit underrun flag |
| orun_o | output | 1 | Sticky receive overrun flag |

## Verification
The index-return rule is the hardest behaviour to reach from the ports. Normal frames never leave the index anywhere but entry 0 at the end. To reach it, the stimulus cuts a frame off after 24 data bits. By then slot 0 has been stored and the receive index points at entry 1. A fresh frame marker follows, and the bench checks that the next frame's first word lands in entry 0 and that transmit starts again from entry 0. Back-to-back frames require host writes and reads to run alongside the serial traffic. The bench therefore forks them into the gap between the slot-1 load and the next frame marker.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } bclk_edge_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/tdm_sync.sv
module tdm_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
   import tdm_port_pkg::*;
#(
   parameter int unsigned SLOT_W         = 16,
   parameter int unsigned NUM_SLOTS      = 2,
   parameter bit          SAMPLE_ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_s_i,
   input  logic fsync_s_i,
   output logic drive_o,
   output logic samp_act_o,
   output logic word_done_o,
   output logic last_slot_o,
   output logic frame_start_o,
   output logic mid_load_o,
   output logic last_load_o,
   output logic fsync_seen_o
);
   localparam int unsigned BIS_W = $clog2(SLOT_W);
   localparam int unsigned SNO_W = $clog2(NUM_SLOTS);
   localparam logic [BIS_W-1:0] BIS_LAST  = BIS_W'(SLOT_W - 1);
   localparam logic [SNO_W-1:0] SNO_LAST  = SNO_W'(NUM_SLOTS - 1);
   localparam logic [SNO_W-1:0] SNO_PENUL = SNO_W'(NUM_SLOTS - 2);

   logic       bclk_d;
   bclk_edge_t edg;
   logic       samp_ev;
   logic       active_q;
   logic [BIS_W-1:0] bis_q;
   logic [SNO_W-1:0] sno_q;
   logic       slot_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= bclk_s_i;
   end

   assign edg.rise = bclk_s_i & ~bclk_d;
   assign edg.fall = ~bclk_s_i & bclk_d;

   generate
      if (SAMPLE_ON_FALL) begin : g_samp_fall
         assign samp_ev = edg.fall;
         assign drive_o = edg.rise;
      end else begin : g_samp_rise
         assign samp_ev = edg.rise;
         assign drive_o = edg.fall;
      end
   endgenerate

   assign frame_start_o = samp_ev & fsync_s_i;
   assign samp_act_o    = samp_ev & active_q;
   assign slot_end      = samp_act_o & (bis_q == BIS_LAST);
   assign word_done_o   = slot_end;
   assign last_slot_o   = slot_end & (sno_q == SNO_LAST);
   assign mid_load_o    = slot_end & (sno_q != SNO_LAST) & ~fsync_s_i;
   assign last_load_o   = mid_load_o & (sno_q == SNO_PENUL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         bis_q    <= '0;
         sno_q    <= '0;
      end else if (frame_start_o) begin
         active_q <= 1'b1;
         bis_q    <= '0;
         sno_q    <= '0;
      end else if (samp_act_o) begin
         if (bis_q == BIS_LAST) begin
            bis_q <= '0;
            if (sno_q == SNO_LAST) begin
               sno_q    <= '0;
               active_q <= 1'b0;
            end else begin
               sno_q <= sno_q + 1'b1;
            end
         end else begin
            bis_q <= bis_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fsync_seen_o <= 1'b0;
      else        fsync_seen_o <= frame_start_o;
   end

   AST_FSEEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_seen_o |=> !fsync_seen_o); // R2
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path #(
   parameter int unsigned SLOT_W    = 16,
   parameter int unsigned HOST_W    = 24,
   parameter int unsigned NUM_SLOTS = 2,
   localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [IDX_W-1:0]  wr_sel_i,
   input  logic [HOST_W-1:0] wdata_i,
   input  logic              frame_start_i,
   input  logic              mid_load_i,
   input  logic              last_load_i,
   input  logic              drive_i,
   input  logic              clr_i,
   output logic              sdout_o,
   output logic              urun_o
);
   logic [NUM_SLOTS-1:0][SLOT_W-1:0] tbuf_q;
   logic [NUM_SLOTS-1:0]             fresh_q;
   logic [IDX_W-1:0]                 idx_q;
   logic [SLOT_W-1:0]                shift_q;
   logic                             load;
   logic [IDX_W-1:0]                 sel;
   logic                             starve;

   assign load   = frame_start_i | mid_load_i;
   assign sel    = frame_start_i ? '0 : idx_q;
   assign starve = load & ~fresh_q[sel];

   generate
      for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tbuf_q[k]  <= '0;
               fresh_q[k] <= 1'b0;
            end else if (wr_i && wr_sel_i == IDX_W'(k)) begin
               tbuf_q[k]  <= wdata_i[HOST_W-1 -: SLOT_W];
               fresh_q[k] <= 1'b1;
            end else if (load && sel == IDX_W'(k)) begin
               fresh_q[k] <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         shift_q <= '0;
         sdout_o <= 1'b0;
      end else if (load) begin
         shift_q <= tbuf_q[sel];
         if (frame_start_i)    idx_q <= IDX_W'(1);
         else if (last_load_i) idx_q <= '0;
         else                  idx_q <= idx_q + 1'b1;
      end else if (drive_i) begin
         sdout_o <= shift_q[SLOT_W-1];
         shift_q <= {shift_q[SLOT_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      urun_o <= 1'b0;
      else if (starve) urun_o <= 1'b1;
      else if (clr_i)  urun_o <= 1'b0;
   end

   AST_SDOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_i |=> $stable(sdout_o)); // R3
   AST_TX_IDX_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      last_load_i |=> (idx_q == '0)); // R6
   AST_URUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (urun_o && !clr_i) |=> urun_o); // R9
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
   parameter int unsigned SLOT_W    = 16,
   parameter int unsigned HOST_W    = 24,
   parameter int unsigned NUM_SLOTS = 2,
   localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sdin_s_i,
   input  logic                 samp_act_i,
   input  logic                 word_done_i,
   input  logic                 last_slot_i,
   input  logic                 frame_start_i,
   input  logic                 rd_i,
   input  logic [IDX_W-1:0]     rd_sel_i,
   input  logic                 clr_i,
   output logic [HOST_W-1:0]    rdata_o,
   output logic [NUM_SLOTS-1:0] valid_o,
   output logic                 orun_o
);
   logic [NUM_SLOTS-1:0][SLOT_W-1:0] rbuf_q;
   logic [NUM_SLOTS-1:0]             unread_q;
   logic [SLOT_W-1:0]                shift_q;
   logic [SLOT_W-1:0]                word;
   logic [IDX_W-1:0]                 idx_q;
   logic                             clobber;

   assign word    = {shift_q[SLOT_W-2:0], sdin_s_i};
   assign clobber = word_done_i & unread_q[idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          shift_q <= '0;
      else if (samp_act_i) shift_q <= word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           idx_q <= '0;
      else if (frame_start_i || last_slot_i) idx_q <= '0;
      else if (word_done_i)                 idx_q <= idx_q + 1'b1;
   end

   generate
      for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rbuf_q[k]   <= '0;
               unread_q[k] <= 1'b0;
               valid_o[k]  <= 1'b0;
            end else begin
               valid_o[k] <= word_done_i && idx_q == IDX_W'(k);
               if (word_done_i && idx_q == IDX_W'(k)) begin
                  rbuf_q[k]   <= word;
                  unread_q[k] <= 1'b1;
               end else if (rd_i && rd_sel_i == IDX_W'(k)) begin
                  unread_q[k] <= 1'b0;
               end
            end
         end
      end

      if (HOST_W > SLOT_W) begin : g_pad
         assign rdata_o = {rbuf_q[rd_sel_i], {(HOST_W-SLOT_W){1'b0}}};
      end else begin : g_nopad
         assign rdata_o = rbuf_q[rd_sel_i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       orun_o <= 1'b0;
      else if (clobber) orun_o <= 1'b1;
      else if (clr_i)   orun_o <= 1'b0;
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(valid_o)); // R5
   AST_RX_IDX_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      last_slot_i |=> (idx_q == '0)); // R6
   AST_ORUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (orun_o && !clr_i) |=> orun_o); // R9
endmodule

// File: rtl/tdm_slave_port.sv
module tdm_slave_port
   import tdm_port_pkg::*;
#(
   parameter int unsigned SLOT_W         = 16,
   parameter int unsigned HOST_W         = 24,
   parameter int unsigned NUM_SLOTS      = 2,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          SAMPLE_ON_FALL = 1'b1,
   localparam int unsigned IDX_W         = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bclk_i,
   input  logic                 fsync_i,
   input  logic                 sdin_i,
   output logic                 sdout_o,
   input  logic                 tx_wr_i,
   input  logic [IDX_W-1:0]     tx_sel_i,
   input  logic [HOST_W-1:0]    tx_wdata_i,
   input  logic                 rx_rd_i,
   input  logic [IDX_W-1:0]     rx_sel_i,
   output logic [HOST_W-1:0]    rx_rdata_o,
   input  logic                 urun_clr_i,
   input  logic                 orun_clr_i,
   output logic [NUM_SLOTS-1:0] rx_valid_o,
   output logic                 fsync_seen_o,
   output logic                 urun_o,
   output logic                 orun_o
);
   generate
      if (SLOT_W > HOST_W || SLOT_W < 2 || NUM_SLOTS < 2 ||
          SYNC_STAGES < MIN_SYNC_STAGES) begin : g_cfg_bad
         $error("tdm_slave_port: unsupported parameter set");
      end
   endgenerate

   logic bclk_s, fsync_s, sdin_s;
   logic drive, samp_act, word_done, last_slot, frame_start, mid_load, last_load;

   tdm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bclk_i, fsync_i, sdin_i}),
      .q_o   ({bclk_s, fsync_s, sdin_s})
   );

   tdm_frame_ctrl #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
                    .SAMPLE_ON_FALL(SAMPLE_ON_FALL)) u_frame (
      .clk           (clk),
      .rst_n         (rst_n),
      .bclk_s_i      (bclk_s),
      .fsync_s_i     (fsync_s),
      .drive_o       (drive),
      .samp_act_o    (samp_act),
      .word_done_o   (word_done),
      .last_slot_o   (last_slot),
      .frame_start_o (frame_start),
      .mid_load_o    (mid_load),
      .last_load_o   (last_load),
      .fsync_seen_o  (fsync_seen_o)
   );

   tdm_tx_path #(.SLOT_W(SLOT_W), .HOST_W(HOST_W), .NUM_SLOTS(NUM_SLOTS)) u_tx (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_i          (tx_wr_i),
      .wr_sel_i      (tx_sel_i),
      .wdata_i       (tx_wdata_i),
      .frame_start_i (frame_start),
      .mid_load_i    (mid_load),
      .last_load_i   (last_load),
      .drive_i       (drive),
      .clr_i         (urun_clr_i),
      .sdout_o       (sdout_o),
      .urun_o        (urun_o)
   );

   tdm_rx_path #(.SLOT_W(SLOT_W), .HOST_W(HOST_W), .NUM_SLOTS(NUM_SLOTS)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .sdin_s_i      (sdin_s),
      .samp_act_i    (samp_act),
      .word_done_i   (word_done),
      .last_slot_i   (last_slot),
      .frame_start_i (frame_start),
      .rd_i          (rx_rd_i),
      .rd_sel_i      (rx_sel_i),
      .clr_i         (orun_clr_i),
      .rdata_o       (rx_rdata_o),
      .valid_o       (rx_valid_o),
      .orun_o        (orun_o)
   );
endmodule

// File: tb/tdm_slave_port_tb_top.sv
module tdm_slave_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
   logic        sdout;
   logic        tx_wr = 1'b0, tx_sel = 1'b0;
   logic [23:0] tx_wdata = '0;
   logic        rx_rd = 1'b0, rx_sel = 1'b0;
   logic [23:0] rx_rdata;
   logic        urun_clr = 1'b0, orun_clr = 1'b0;
   logic [1:0]  rx_valid;
   logic        fsync_seen, urun, orun;

   int n_chk = 0, n_fail = 0;
   int v0_cnt = 0, v1_cnt = 0, fs_cnt = 0;

   always #5 clk = ~clk;

   tdm_slave_port dut_i (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdin_i(sdin),
      .sdout_o(sdout), .tx_wr_i(tx_wr), .tx_sel_i(tx_sel), .tx_wdata_i(tx_wdata),
      .rx_rd_i(rx_rd), .rx_sel_i(rx_sel), .rx_rdata_o(rx_rdata),
      .urun_clr_i(urun_clr), .orun_clr_i(orun_clr), .rx_valid_o(rx_valid),
      .fsync_seen_o(fsync_seen), .urun_o(urun), .orun_o(orun)
   );

   always @(negedge clk) begin
      if (rx_valid[0]) v0_cnt++;
      if (rx_valid[1]) v1_cnt++;
      if (fsync_seen)  fs_cnt++;
   end

   // {tx slot0, tx slot1, rx slot0, rx slot1}
   localparam logic [63:0] VEC [4] = '{
      {16'hA55A, 16'h0F0F, 16'h1234, 16'hFEDC},
      {16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF},
      {16'h8001, 16'h7FFE, 16'hC003, 16'h3FFC},
      {16'h0001, 16'h8000, 16'h5AA5, 16'h6996}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_wr(input logic sel, input logic [15:0] w);
      @(negedge clk);
      tx_wr = 1'b1; tx_sel = sel; tx_wdata = {w, 8'h5C};
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic host_rd(input logic sel, output logic [23:0] d);
      @(negedge clk);
      rx_sel = sel;
      #1 d = rx_rdata;
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic pulse_clr(input bit which_orun);
      @(negedge clk);
      if (which_orun) orun_clr = 1'b1; else urun_clr = 1'b1;
      @(negedge clk);
      orun_clr = 1'b0; urun_clr = 1'b0;
   endtask

   task automatic bit_period(input logic fs, input logic din, output logic so);
      @(negedge clk);
      bclk = 1'b1; fsync = fs; sdin = din;
      repeat (4) @(negedge clk);
      so = sdout;
      bclk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic run_frame(input logic [15:0] r0, input logic [15:0] r1,
                            input bit lead, input bit tail, input int nbits,
                            output logic [31:0] got);
      logic so;
      logic [31:0] rx = {r0, r1};
      got = '0;
      if (lead) bit_period(1'b1, 1'b0, so);
      for (int p = 0; p < nbits; p++) begin
         bit_period((p == 31) && tail, rx[31-p], so);
         got[31-p] = so;
      end
      fsync = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] got, got2;
      logic [23:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sdout", {31'd0, sdout}, 0);
      chk("R1 flags", {29'd0, urun, orun, fsync_seen}, 0);
      chk("R1 valid", {30'd0, rx_valid}, 0);
      chk("R1 rdata", {8'd0, rx_rdata}, 0);

      for (int v = 0; v < 4; v++) begin
         host_wr(1'b0, VEC[v][63:48]);
         host_wr(1'b1, VEC[v][47:32]);
         v0_cnt = 0; v1_cnt = 0; fs_cnt = 0;
         run_frame(VEC[v][31:16], VEC[v][15:0], 1, 0, 32, got);
         chk("R3 tx frame", got, VEC[v][63:32]);
         host_rd(1'b0, d);
         chk("R4 rx slot0", {8'd0, d}, {8'd0, VEC[v][31:16], 8'h00});
         host_rd(1'b1, d);
         chk("R4 rx slot1", {8'd0, d}, {8'd0, VEC[v][15:0], 8'h00});
         chk("R5 strobes", {v0_cnt[15:0], v1_cnt[15:0]}, {16'd1, 16'd1});
         chk("R2 fsync seen", fs_cnt, 1);
         chk("R7 R8 no errors", {30'd0, urun, orun}, 0);
      end

      // R7 underrun: no fresh writes, previous words resent
      run_frame(16'h1111, 16'h2222, 1, 0, 32, got);
      chk("R7 resend", got, VEC[3][63:32]);
      chk("R7 urun set", {31'd0, urun}, 1);
      host_rd(1'b0, d); host_rd(1'b1, d);
      repeat (20) @(negedge clk);
      chk("R9 urun sticky", {31'd0, urun}, 1);
      pulse_clr(1'b0);
      chk("R9 urun cleared", {31'd0, urun}, 0);

      // R8 overrun
      host_wr(1'b0, 16'h3C3C); host_wr(1'b1, 16'hC3C3);
      run_frame(16'hAAAA, 16'hBBBB, 1, 0, 32, got);
      chk("R8 no orun yet", {31'd0, orun}, 0);
      host_wr(1'b0, 16'h3C3C); host_wr(1'b1, 16'hC3C3);
      run_frame(16'hCCCC, 16'hDDDD, 1, 0, 32, got);
      chk("R8 orun set", {31'd0, orun}, 1);
      host_rd(1'b0, d);
      chk("R8 newest kept", {8'd0, d}, {8'd0, 16'hCCCC, 8'h00});
      host_rd(1'b1, d);
      pulse_clr(1'b1);
      chk("R9 orun cleared", {31'd0, orun}, 0);

      // R6 frame cut short after slot 0 stored, then resync
      host_wr(1'b0, 16'h1357); host_wr(1'b1, 16'h2468);
      run_frame(16'h9E37, 16'h0000, 1, 0, 24, got);
      host_rd(1'b0, d);
      chk("R6 partial slot0", {8'd0, d}, {8'd0, 16'h9E37, 8'h00});
      host_wr(1'b0, 16'hBEEF); host_wr(1'b1, 16'hCAFE);
      v0_cnt = 0; v1_cnt = 0;
      run_frame(16'h4D2B, 16'h71E8, 1, 0, 32, got);
      chk("R6 tx restarts at entry 0", got, {16'hBEEF, 16'hCAFE});
      chk("R6 strobes after resync", {v0_cnt[15:0], v1_cnt[15:0]}, {16'd1, 16'd1});
      host_rd(1'b0, d);
      chk("R6 rx restarts at entry 0", {8'd0, d}, {8'd0, 16'h4D2B, 8'h00});
      host_rd(1'b1, d);
      chk("R6 rx slot1", {8'd0, d}, {8'd0, 16'h71E8, 8'h00});
      chk("R6 no errors", {30'd0, urun, orun}, 0);

      // R10 back-to-back frames, marker during data bit 31
      host_wr(1'b0, 16'h0A0B); host_wr(1'b1, 16'h0C0D);
      fs_cnt = 0;
      fork
         run_frame(16'hE1E2, 16'hE3E4, 1, 1, 32, got);
         begin
            repeat (200) @(negedge clk);
            host_wr(1'b0, 16'h5150); host_wr(1'b1, 16'h5352);
            host_rd(1'b0, d);
         end
      join
      chk("R10 first rx slot0", {8'd0, d}, {8'd0, 16'hE1E2, 8'h00});
      chk("R10 first tx", got, {16'h0A0B, 16'h0C0D});
      host_rd(1'b1, d);
      chk("R10 first rx slot1", {8'd0, d}, {8'd0, 16'hE3E4, 8'h00});
      run_frame(16'h7788, 16'h99AA, 0, 0, 32, got2);
      chk("R10 second tx", got2, {16'h5150, 16'h5352});
      host_rd(1'b0, d);
      chk("R10 second rx slot0", {8'd0, d}, {8'd0, 16'h7788, 8'h00});
      host_rd(1'b1, d);
      chk("R10 second rx slot1", {8'd0, d}, {8'd0, 16'h99AA, 8'h00});
      chk("R2 R10 two starts", fs_cnt, 2);
      chk("R10 no errors", {30'd0, urun, orun}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule